// File: doc/BRIEF.md
# I2C Bit-Clock Prescaler with SDA Output Delay

This block sets the serial clock timing of an I2C master from the peripheral clock. A coarse pre-divider, fixed at either 16 or 512 by one select bit, feeds a 4-bit scale divider whose divisor is the scale field plus one. The full SCL period is therefore the pre-divisor times the scale divisor, in peripheral clocks. Each half period ends with a one-cycle phase tick, and the generated SCL level toggles in that same cycle. The byte sequencer uses these ticks to shift bits.

The block also holds back the sequencer's SDA drive request after each falling SCL edge. The hold lasts zero, five, ten or fifteen peripheral clocks, chosen by a 2-bit field, so that data changes well inside the SCL low phase. On the receive side, both bus lines pass through a switchable glitch filter. With the filter on, a line sample takes a new level only after the raw line has held that level for three consecutive clocks.

The pre-divide select, scale and delay fields are latched at each half-period boundary. While serial output is disabled, the counters are held at zero and SCL rests high.

Top module: `i2c_scl_prescaler`

## Requirements
- R1: While `out_en` is low, `scl_out` is 1, `phase_tick` is 0 and `sda_oe` is 0. After reset, both line samples are 1.
- R2: With `pre_sel` = 0, `phase_tick` pulses every 8·(scale+1) clocks, so the SCL period is 16·(scale+1) clocks. The first pulse comes on the 8·(scale+1)-th clock edge after `out_en` is seen high.
- R3: With `pre_sel` = 1, `phase_tick` pulses every 256·(scale+1) clocks, so the SCL period is 512·(scale+1) clocks.
- R4: The scale field covers its full range: scale 0 divides by 1 and scale 15 divides by 16.
- R5: `phase_tick` is high for exactly one cycle. `scl_out` changes only in a cycle where `phase_tick` is high while enabled, and the first change after enable is from 1 to 0.
- R6: A change of `pre_sel`, `scale` or `sda_dly` made in the middle of a half period does not alter that half period. It takes effect from the next `phase_tick`.
- R7: When `sda_req` changes in the cycle where `scl_out` falls, `sda_oe` takes the new value 1 + 5·`sda_dly` clocks later (encoding 0, 1, 2, 3 gives 0, 5, 10, 15 clocks of delay). It keeps its old value until then.
- R8: Outside the hold window after a falling SCL edge, a change of `sda_req` reaches `sda_oe` one clock later.
- R9: With `filt_en` = 0, `scl_smp` and `sda_smp` follow the raw lines with one clock of latency, and a one-clock glitch passes through.
- R10: With `filt_en` = 1, a line sample changes exactly three clocks after the raw line settles at a new level. A pulse lasting two clocks or less is ignored.
- R11: Dropping `out_en` sets `scl_out` high at the next clock. On re-enable, counting restarts from zero, so the first half period has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Serial output enable; low holds the dividers in reset |
| pre_sel | input | 1 | Pre-divide select: 0 for 16, 1 for 512 |
| scale | input | 4 | Second-stage scale; divisor is scale+1 |
| sda_dly | input | 2 | SDA hold after SCL fall, in steps of 5 clocks |
| filt_en | input | 1 | Enables the input glitch filter on both lines |
| sda_req | input | 1 | SDA drive-low request from the byte sequencer |
| scl_raw | input | 1 | Raw SCL line level |
| sda_raw | input | 1 | Raw SDA line level |
| scl_out | output | 1 | Generated SCL level |
| phase_tick | output | 1 | One-cycle pulse at each SCL half-period boundary |
| sda_oe | output | 1 | Delayed SDA drive-low enable |
| scl_smp | output | 1 | Filtered SCL sample |
| sda_smp | output | 1 | Filtered SDA sample |

## Verification
The bench uses the default parameters: pre-divisors of 16 and 512, a delay step of 5 and a filter length of 3. With these values, even the slow 512 setting gives half periods of only a few hundred clocks, so both pre-divide selections and both scale extremes are measured edge by edge. The 16-clock SCL low phase at scale 1 is long enough to show every delay code, including 15 clocks, completing before the next rising edge. Each filter case, a two-clock rejection and a three-clock acceptance, needs only a handful of cycles on each line.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;

    localparam int SCALE_W = 4;
    localparam int DLY_W   = 2;

    // Timing fields that are sampled at half-period boundaries
    typedef struct packed {
        logic               pre_hi;
        logic [SCALE_W-1:0] scale;
        logic [DLY_W-1:0]   dly_sel;
    } tmr_cfg_t;

endpackage

// File: rtl/scl_phase_div.sv
module scl_phase_div
    import i2c_tmr_pkg::*;
#(
    parameter int PRE_LO_DIV = 16,
    parameter int PRE_HI_DIV = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmr_cfg_t         cfg_in,
    output logic [DLY_W-1:0] dly_act,
    output logic             scl_o,
    output logic             tick_o,
    output logic             fall_o
);

    localparam int HALF_LO = PRE_LO_DIV / 2;
    localparam int HALF_HI = PRE_HI_DIV / 2;
    localparam int PW      = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;

    typedef struct packed {
        logic [PW-1:0]      pre_cnt;
        logic [SCALE_W-1:0] sc_cnt;
        logic               scl;
        logic               tick;
        logic               fall;
        tmr_cfg_t           cfg;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [PW-1:0] pre_last;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.fall = 1'b0;
        pre_last  = st_q.cfg.pre_hi ? PW'(HALF_HI - 1) : PW'(HALF_LO - 1);
        if (!run) begin
            st_d.pre_cnt = '0;
            st_d.sc_cnt  = '0;
            st_d.scl     = 1'b1;
            st_d.cfg     = cfg_in;
        end else if (st_q.pre_cnt == pre_last) begin
            st_d.pre_cnt = '0;
            if (st_q.sc_cnt == st_q.cfg.scale) begin
                st_d.sc_cnt = '0;
                st_d.scl    = ~st_q.scl;
                st_d.tick   = 1'b1;
                st_d.fall   = st_q.scl;
                st_d.cfg    = cfg_in;
            end else begin
                st_d.sc_cnt = st_q.sc_cnt + 1'b1;
            end
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.scl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_act = st_q.cfg.dly_sel;
    assign scl_o   = st_q.scl;
    assign tick_o  = st_q.tick;
    assign fall_o  = st_q.fall;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_o && !tick_o)); // R1

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && (st_q.cfg.pre_hi || st_q.cfg.scale != '0 || HALF_LO > 1) |=> !tick_o); // R5

    AST_SCL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && $past(run)) |-> $stable(scl_o)); // R5

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pre_cnt <= (st_q.cfg.pre_hi ? PW'(HALF_HI - 1) : PW'(HALF_LO - 1))); // R2

    AST_SCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sc_cnt <= st_q.cfg.scale); // R4

endmodule

// File: rtl/sda_out_delay.sv
module sda_out_delay
    import i2c_tmr_pkg::*;
#(
    parameter int DLY_STEP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fall,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             req,
    output logic             oe_o
);

    localparam int MAXD = ((1 << DLY_W) - 1) * DLY_STEP;
    localparam int CW   = $clog2(MAXD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          oe;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic [CW-1:0] dly_clks;

    always_comb begin
        st_d     = st_q;
        dly_clks = CW'(dly_sel) * CW'(DLY_STEP);
        if (!run) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (fall) begin
            if (dly_clks == '0) begin
                st_d.oe = req;
            end else begin
                st_d.cnt = dly_clks - 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.oe = req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o = st_q.oe;

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !oe_o); // R1

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fall && st_q.cnt != '0) |=> $stable(oe_o)); // R7

    AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fall && dly_sel != '0) |=> $stable(oe_o)); // R7

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(MAXD)); // R7

endmodule

// File: rtl/line_glitch_filter.sv
module line_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic line_o
);

    localparam int HW = (FILT_LEN > 1) ? FILT_LEN - 1 : 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          line;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic [HW:0] win;

    always_comb begin
        st_d      = st_q;
        win       = {st_q.hist, raw};
        st_d.hist = win[HW-1:0];
        if (!en) begin
            st_d.line = raw;
        end else if (&win) begin
            st_d.line = 1'b1;
        end else if (~|win) begin
            st_d.line = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;

    AST_FILT_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(raw) == line_o)); // R9

    AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (line_o != $past(line_o))) |-> ($past(raw, 2) == line_o)); // R10

endmodule

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler
    import i2c_tmr_pkg::*;
#(
    parameter int PRE_LO_DIV = 16,
    parameter int PRE_HI_DIV = 512,
    parameter int DLY_STEP   = 5,
    parameter int FILT_LEN   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               out_en,
    input  logic               pre_sel,
    input  logic [SCALE_W-1:0] scale,
    input  logic [DLY_W-1:0]   sda_dly,
    input  logic               filt_en,
    input  logic               sda_req,
    input  logic               scl_raw,
    input  logic               sda_raw,
    output logic               scl_out,
    output logic               phase_tick,
    output logic               sda_oe,
    output logic               scl_smp,
    output logic               sda_smp
);

    localparam int NLINES = 2;

    tmr_cfg_t         cfg_in;
    logic [DLY_W-1:0] dly_act;
    logic             scl_fall;
    logic [NLINES-1:0] raw_v;
    logic [NLINES-1:0] smp_v;

    assign cfg_in = '{pre_hi: pre_sel, scale: scale, dly_sel: sda_dly};

    scl_phase_div #(
        .PRE_LO_DIV(PRE_LO_DIV),
        .PRE_HI_DIV(PRE_HI_DIV)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (out_en),
        .cfg_in (cfg_in),
        .dly_act(dly_act),
        .scl_o  (scl_out),
        .tick_o (phase_tick),
        .fall_o (scl_fall)
    );

    sda_out_delay #(
        .DLY_STEP(DLY_STEP)
    ) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (out_en),
        .fall   (scl_fall),
        .dly_sel(dly_act),
        .req    (sda_req),
        .oe_o   (sda_oe)
    );

    assign raw_v = {sda_raw, scl_raw};

    for (genvar li = 0; li < NLINES; li++) begin : g_line
        line_glitch_filter #(
            .FILT_LEN(FILT_LEN)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (filt_en),
            .raw   (raw_v[li]),
            .line_o(smp_v[li])
        );
    end

    assign scl_smp = smp_v[0];
    assign sda_smp = smp_v[1];

    AST_FALL_MATCHES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (phase_tick && !scl_out)); // R7

endmodule

// File: tb/tb_i2c_scl_prescaler.sv
module tb_i2c_scl_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b0;
    logic       pre_sel = 1'b0;
    logic [3:0] scale = 4'd0;
    logic [1:0] sda_dly = 2'd0;
    logic       filt_en = 1'b0;
    logic       sda_req = 1'b0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       scl_out, phase_tick, sda_oe, scl_smp, sda_smp;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    i2c_scl_prescaler dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .pre_sel   (pre_sel),
        .scale     (scale),
        .sda_dly   (sda_dly),
        .filt_en   (filt_en),
        .sda_req   (sda_req),
        .scl_raw   (scl_raw),
        .sda_raw   (sda_raw),
        .scl_out   (scl_out),
        .phase_tick(phase_tick),
        .sda_oe    (sda_oe),
        .scl_smp   (scl_smp),
        .sda_smp   (sda_smp)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!phase_tick && n < 5000);
    endtask

    task automatic setup_run(input logic p, input int sc, input int dl);
        out_en  = 1'b0;
        pre_sel = p;
        scale   = 4'(sc);
        sda_dly = 2'(dl);
        repeat (2) @(negedge clk);
        out_en = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "scl idle", int'(scl_out), 1);
        chk("R1", "tick idle", int'(phase_tick), 0);
        chk("R1", "oe idle", int'(sda_oe), 0);
        chk("R1", "scl sample", int'(scl_smp), 1);
        chk("R1", "sda sample", int'(sda_smp), 1);
    endtask

    task automatic t_period(input string tag, input logic p, input int sc);
        int n;
        int half;
        half = (p ? 256 : 8) * (sc + 1);
        setup_run(p, sc, 0);
        wait_tick(n);
        chk(tag, "first half period", n, half);
        chk("R5", "scl falls first", int'(scl_out), 0);
        @(negedge clk);
        chk("R5", "tick one cycle", int'(phase_tick), 0);
        wait_tick(n);
        chk(tag, "second half period", n + 1, half);
        chk("R5", "scl rises", int'(scl_out), 1);
        out_en = 1'b0;
    endtask

    task automatic t_cfg_change();
        int n;
        setup_run(1'b0, 0, 0);
        wait_tick(n);
        scale = 4'd2;
        wait_tick(n);
        chk("R6", "old scale kept", n, 8);
        wait_tick(n);
        chk("R6", "new scale used", n, 24);
        out_en = 1'b0;
    endtask

    task automatic t_disable();
        int n;
        setup_run(1'b0, 1, 0);
        wait_tick(n);
        repeat (5) @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        chk("R11", "scl high when disabled", int'(scl_out), 1);
        chk("R11", "no tick when disabled", int'(phase_tick), 0);
        repeat (3) @(negedge clk);
        out_en = 1'b1;
        wait_tick(n);
        chk("R11", "full first half after restart", n, 16);
        out_en = 1'b0;
    endtask

    task automatic t_delay(input int sel);
        int n;
        sda_req = 1'b0;
        setup_run(1'b0, 1, sel);
        do wait_tick(n); while (scl_out != 1'b0);
        sda_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sda_oe != 1'b1 && n < 100);
        chk("R7", $sformatf("delay code %0d", sel), n, 1 + 5 * sel);
        out_en  = 1'b0;
        sda_req = 1'b0;
    endtask

    task automatic t_passthrough();
        int n;
        sda_req = 1'b0;
        setup_run(1'b0, 1, 2);
        do wait_tick(n); while (scl_out != 1'b0);
        wait_tick(n);
        chk("R8", "at rising edge", int'(scl_out), 1);
        sda_req = 1'b1;
        @(negedge clk);
        chk("R8", "oe follows next clock", int'(sda_oe), 1);
        sda_req = 1'b0;
        @(negedge clk);
        chk("R8", "oe releases next clock", int'(sda_oe), 0);
        out_en = 1'b0;
    endtask

    task automatic drive_line(input int ln, input logic v);
        if (ln == 0) scl_raw = v;
        else sda_raw = v;
    endtask

    function automatic int line_smp(input int ln);
        return (ln == 0) ? int'(scl_smp) : int'(sda_smp);
    endfunction

    task automatic t_filter_off(input int ln);
        filt_en = 1'b0;
        @(negedge clk);
        drive_line(ln, 1'b0);
        @(negedge clk);
        chk("R9", $sformatf("glitch passes line %0d", ln), line_smp(ln), 0);
        drive_line(ln, 1'b1);
        @(negedge clk);
        chk("R9", $sformatf("level restored line %0d", ln), line_smp(ln), 1);
    endtask

    task automatic t_filter_on(input int ln);
        int n;
        filt_en = 1'b1;
        repeat (3) @(negedge clk);
        drive_line(ln, 1'b0);
        @(negedge clk);
        chk("R10", $sformatf("short pulse held line %0d", ln), line_smp(ln), 1);
        @(negedge clk);
        chk("R10", $sformatf("short pulse held line %0d", ln), line_smp(ln), 1);
        drive_line(ln, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", $sformatf("short pulse rejected line %0d", ln), line_smp(ln), 1);
        drive_line(ln, 1'b0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (line_smp(ln) != 0 && n < 20);
        chk("R10", $sformatf("fall accepted line %0d", ln), n, 3);
        drive_line(ln, 1'b1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (line_smp(ln) != 1 && n < 20);
        chk("R10", $sformatf("rise accepted line %0d", ln), n, 3);
        filt_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_period("R2", 1'b0, 3);
        t_period("R4", 1'b0, 0);
        t_period("R4", 1'b0, 15);
        t_period("R3", 1'b1, 0);
        t_period("R3", 1'b1, 1);
        t_cfg_change();
        t_disable();
        for (int s = 0; s < 4; s++) t_delay(s);
        t_passthrough();
        for (int l = 0; l < 2; l++) begin
            t_filter_off(l);
            t_filter_on(l);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule